// File: doc/BRIEF.md
# Configuration Stream Host

This block loads a configuration image into a target device over a source-synchronous valid/data port. After a start request, it drives the target's active-low configuration request line high, then low for a programmable number of cycles, then high again. This clears the target. The block then waits for the target's status line to rise, with a timeout. Once status is up, it moves image words from an upstream word source to the target. When the last word has left, it waits for the target's done line and reports either completion or an error.

The upstream side is a valid/ready stream. A word moves on a clock edge where `src_valid_i` and `src_ready_o` are both high. `src_last_i` marks the final word of the image. `src_ready_o` is high only while streaming, and only while the synchronized target ready and target status are both high. The source may hold `src_valid_i` low for any number of cycles.

The target side has no upstream handshake. The target ready pin is asynchronous and reaches the logic through a two-flop synchronizer. Words already issued keep flowing through a `PIPE_DEPTH`-stage output pipeline after ready falls. An elaboration check ties this overrun to the budget `RDY_LAT`. The target clock output is the block clock, forwarded without gating.

Top module: `cfg_stream_host`

## Requirements
- R1: While reset is asserted and after it is released, `tgt_cfg_n_o` is 1 and `tgt_valid_o`, `src_ready_o`, `cfg_done_o` and `cfg_err_o` are 0 until `start_i` is seen.
- R2: A start in the idle, done or error state holds `tgt_cfg_n_o` low for exactly `PULSE_CYC` consecutive cycles, then returns it high. No word is issued or presented while it is low.
- R3: `tgt_ready_i` and `tgt_status_i` each pass through two flops reset to 0. With status high and a source word waiting, the first `tgt_valid_o` appears exactly `2 + PIPE_DEPTH` cycles after the ready pin rises.
- R4: After the ready pin falls, at most `2 + PIPE_DEPTH` further words appear at the target. This count includes the word already on the pins. `2 + PIPE_DEPTH` is at most `RDY_LAT`, and `RDY_LAT` lies in 1..6.
- R5: If status falls while streaming, `cfg_err_o` is set on the third rising edge after the fall. On that same edge the output pipeline is cleared, and it presents no words while in error.
- R6: Words reach `tgt_data_o` unchanged, `DATA_W` bits wide, in source order, with none lost or repeated, under any pattern of source stalls and target ready changes.
- R7: After the last word has drained and the done pin is seen high through its synchronizer, `cfg_done_o` rises with the pipeline empty.
- R8: If done is not seen within `DONE_TMO` cycles after the last word is accepted, `cfg_err_o` is set and `cfg_done_o` stays 0.
- R9: If status does not rise after the pulse, `cfg_err_o` rises exactly `STAT_TMO` cycles after `tgt_cfg_n_o` returns high.
- R10: `tgt_clk_o` follows `clk` at all times, including in idle, error and done.
- R11: While status is low, a high ready pin has no effect: `src_ready_o` and `tgt_valid_o` stay 0.
- R12: A start from the done or error state runs a complete new sequence, from the pulse through to streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and streaming clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence |
| src_valid_i | input | 1 | Upstream word available |
| src_data_i | input | DATA_W | Upstream word |
| src_last_i | input | 1 | Marks the final image word |
| src_ready_o | output | 1 | Upstream word accepted on this edge when valid |
| tgt_clk_o | output | 1 | Free-running clock to the target |
| tgt_cfg_n_o | output | 1 | Active-low configuration request to the target |
| tgt_status_i | input | 1 | Target status, asynchronous |
| tgt_ready_i | input | 1 | Target ready, asynchronous |
| tgt_done_i | input | 1 | Target configuration finished, asynchronous |
| tgt_data_o | output | DATA_W | Word to the target |
| tgt_valid_o | output | 1 | `tgt_data_o` carries a word |
| cfg_done_o | output | 1 | Configuration completed |
| cfg_err_o | output | 1 | Sequence aborted on timeout or status loss |

## Verification
The bench measures the exact delay from a rising ready pin to the first word. It also counts the words that still appear after a falling ready pin. A synchronizer with a missing or extra stage, or a pipeline that keeps issuing past the bound, moves these numbers off `2 + PIPE_DEPTH`. It drops status in mid-stream and checks that the error comes on the third edge with no word after it; a design that kept flushing words or ignored status would fail here. It also pins the status timeout to the exact cycle and streams randomly stalled traffic under random ready toggling, so that a lost, repeated or reordered word shows up as a data mismatch.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE  = 3'd1,
    ST_WSTAT  = 3'd2,
    ST_STREAM = 3'd3,
    ST_WDONE  = 3'd4,
    ST_DONE   = 3'd5,
    ST_ERR    = 3'd6
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfgh_sync.sv
// Multi-bit bank of independent flop chains for asynchronous inputs.
module cfgh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (STAGES < 2) begin : g_bad_stages
    $error("cfgh_sync needs at least two stages");
  end

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgh_pipe.sv
// Output pipeline toward the target. It never stalls: words in flight always
// drain, and the whole pipeline is cleared at once on flush.
module cfgh_pipe #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          empty_o
);

  if (DEPTH < 1) begin : g_bad_depth
    $error("cfgh_pipe needs at least one stage");
  end

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    dat_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
    end else begin
      vld_q[0] <= in_valid_i & ~flush_i;
      if (in_valid_i) dat_q[0] <= in_data_i;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i] <= vld_q[i-1] & ~flush_i;
        if (vld_q[i-1]) dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign out_valid_o = vld_q[DEPTH-1];
  assign out_data_o  = dat_q[DEPTH-1];
  assign empty_o     = ~|vld_q;

endmodule

// File: rtl/cfgh_seq.sv
// Sequencer: request pulse, status wait, streaming, done wait.
module cfgh_seq import cfgh_pkg::*; #(
  parameter int PULSE_CYC = 8,
  parameter int STAT_TMO  = 64,
  parameter int DONE_TMO  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stat_ok_i,
  input  logic       rdy_ok_i,
  input  logic       done_ok_i,
  input  logic       src_valid_i,
  input  logic       src_last_i,
  input  logic       pipe_empty_i,
  output seq_state_e state_o,
  output logic       issue_o,
  output logic       src_ready_o,
  output logic       flush_o,
  output logic       cfg_n_o
);

  localparam int MAXC = max3(PULSE_CYC, STAT_TMO, DONE_TMO);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] STAT_LAST  = CW'(STAT_TMO - 1);
  localparam logic [CW-1:0] DONE_LAST  = CW'(DONE_TMO - 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr, cnt_inc;
  logic          cfg_n_q;

  assign src_ready_o = (st_q == ST_STREAM) && rdy_ok_i;
  assign issue_o     = src_ready_o && src_valid_i;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_PULSE;
          cnt_clr = 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          st_d    = ST_WSTAT;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_WSTAT: begin
        if (stat_ok_i) begin
          st_d    = ST_STREAM;
          cnt_clr = 1'b1;
        end else if (cnt_q == STAT_LAST) begin
          st_d = ST_ERR;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_STREAM: begin
        if (!stat_ok_i) begin
          st_d = ST_ERR;
        end else if (issue_o && src_last_i) begin
          st_d    = ST_WDONE;
          cnt_clr = 1'b1;
        end
      end
      ST_WDONE: begin
        if (pipe_empty_i && done_ok_i) begin
          st_d = ST_DONE;
        end else if (cnt_q == DONE_LAST) begin
          st_d = ST_ERR;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_DONE, ST_ERR: begin
        if (start_i) begin
          st_d    = ST_PULSE;
          cnt_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign flush_o = (st_d == ST_ERR) && (st_q != ST_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cfg_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cfg_n_q <= (st_d != ST_PULSE);
      if (cnt_clr)      cnt_q <= '0;
      else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = st_q;
  assign cfg_n_o = cfg_n_q;

endmodule

// File: rtl/cfg_stream_host.sv
module cfg_stream_host import cfgh_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int PIPE_DEPTH = 2,
  parameter int RDY_LAT    = 4,
  parameter int PULSE_CYC  = 8,
  parameter int STAT_TMO   = 64,
  parameter int DONE_TMO   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_last_i,
  output logic              src_ready_o,
  output logic              tgt_clk_o,
  output logic              tgt_cfg_n_o,
  input  logic              tgt_status_i,
  input  logic              tgt_ready_i,
  input  logic              tgt_done_i,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              tgt_valid_o,
  output logic              cfg_done_o,
  output logic              cfg_err_o
);

  localparam int SYNC_STAGES = 2;
  localparam int OVERRUN     = SYNC_STAGES + PIPE_DEPTH;
  localparam int N_ASYNC     = 3;

  if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_width
    $error("DATA_W must be 8, 16 or 32");
  end
  if (RDY_LAT < 1 || RDY_LAT > 6) begin : g_bad_lat
    $error("RDY_LAT must lie in 1..6");
  end
  if (OVERRUN > RDY_LAT) begin : g_bad_overrun
    $error("synchronizer plus pipeline depth exceeds the ready latency budget");
  end
  if (PULSE_CYC < SYNC_STAGES + 2) begin : g_bad_pulse
    $error("PULSE_CYC too short to flush stale status through the synchronizer");
  end

  logic [N_ASYNC-1:0] async_in, async_s;
  logic               rdy_s, stat_s, done_s, rdy_ok;
  logic               issue, flush, pipe_empty;
  seq_state_e         state;

  assign async_in = {tgt_done_i, tgt_status_i, tgt_ready_i};

  cfgh_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_in),
    .q_o   (async_s)
  );

  assign rdy_s  = async_s[0];
  assign stat_s = async_s[1];
  assign done_s = async_s[2];
  assign rdy_ok = rdy_s & stat_s;

  cfgh_seq #(
    .PULSE_CYC (PULSE_CYC),
    .STAT_TMO  (STAT_TMO),
    .DONE_TMO  (DONE_TMO)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stat_ok_i    (stat_s),
    .rdy_ok_i     (rdy_ok),
    .done_ok_i    (done_s),
    .src_valid_i  (src_valid_i),
    .src_last_i   (src_last_i),
    .pipe_empty_i (pipe_empty),
    .state_o      (state),
    .issue_o      (issue),
    .src_ready_o  (src_ready_o),
    .flush_o      (flush),
    .cfg_n_o      (tgt_cfg_n_o)
  );

  cfgh_pipe #(.DW(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .in_valid_i  (issue),
    .in_data_i   (src_data_i),
    .out_valid_o (tgt_valid_o),
    .out_data_o  (tgt_data_o),
    .empty_o     (pipe_empty)
  );

  assign tgt_clk_o  = clk;
  assign cfg_done_o = (state == ST_DONE);
  assign cfg_err_o  = (state == ST_ERR);

endmodule

// File: rtl/cfg_stream_host_chk.sv
module cfg_stream_host_chk #(
  parameter int RDY_LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tgt_cfg_n_o,
  input logic tgt_ready_i,
  input logic tgt_valid_o,
  input logic src_ready_o,
  input logic cfg_done_o,
  input logic cfg_err_o
);

  // Words the target samples on edges where its ready pin is low.
  logic [3:0] ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= '0;
    end else if (tgt_ready_i) begin
      ovr_q <= '0;
    end else if (tgt_valid_o && ovr_q < 4'(RDY_LAT + 1)) begin
      ovr_q <= ovr_q + 1'b1;
    end
  end

  // R2
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_cfg_n_o |-> (!tgt_valid_o && !src_ready_o));

  // R3
  ready_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> $past(tgt_ready_i, 2));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q <= 4'(RDY_LAT));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!tgt_valid_o && !src_ready_o));

  // R7
  done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done_o) |-> !tgt_valid_o);

endmodule

bind cfg_stream_host cfg_stream_host_chk #(.RDY_LAT(RDY_LAT)) u_chk (.*);

// File: tb/cfg_stream_host_tb.sv
`timescale 1ns/1ps
module cfg_stream_host_tb;

  localparam int DW = 16;
  localparam int PIPE = 2;
  localparam int LAT = 4;
  localparam int PULSE = 8;
  localparam int STMO = 40;
  localparam int DTMO = 50;
  localparam int BOUND = 2 + PIPE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic src_last = 1'b0;
  logic src_ready;
  logic tgt_clk, tgt_cfg_n, tgt_status, tgt_valid, cfg_done, cfg_err;
  logic tgt_ready = 1'b0;
  logic tgt_done = 1'b0;
  logic [DW-1:0] tgt_data;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] words [256];
  int sidx = 0, ridx = 0, src_len = 0, avail = 100;
  bit src_en = 0, src_rst = 0, fire = 0;
  bit model_stat = 0, auto_stat = 1, force_low = 0;
  int sdly = 0, mism = 0, bad_pulse = 0, err_viol = 0, clk_bad = 0, clk_seen = 0;

  always #2.5 clk = ~clk;

  assign tgt_status = model_stat & ~force_low;

  cfg_stream_host #(
    .DATA_W(DW), .PIPE_DEPTH(PIPE), .RDY_LAT(LAT),
    .PULSE_CYC(PULSE), .STAT_TMO(STMO), .DONE_TMO(DTMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_last_i(src_last),
    .src_ready_o(src_ready), .tgt_clk_o(tgt_clk), .tgt_cfg_n_o(tgt_cfg_n),
    .tgt_status_i(tgt_status), .tgt_ready_i(tgt_ready), .tgt_done_i(tgt_done),
    .tgt_data_o(tgt_data), .tgt_valid_o(tgt_valid),
    .cfg_done_o(cfg_done), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic reset_src();
    @(negedge clk); src_en = 0; src_rst = 1;
    negs(2); src_rst = 0;
  endtask

  // Drops ready at a negedge and counts words the target still receives.
  task automatic drop_count(output int cnt);
    @(negedge clk);
    cnt = int'(tgt_valid);
    tgt_ready = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      cnt += int'(tgt_valid);
    end
    @(negedge clk);
  endtask

  // Upstream word source model.
  always @(negedge clk) begin
    if (src_rst) begin
      sidx = 0; fire = 0;
    end else if (fire) begin
      sidx++;
    end
    if (!src_rst && src_en && sidx < src_len && ($urandom % 100) < avail) begin
      src_valid = 1'b1; src_data = words[sidx]; src_last = (sidx == src_len - 1);
    end else begin
      src_valid = 1'b0; src_last = 1'b0;
    end
    fire = src_valid && src_ready;
  end

  // Target status model: low while requested, rises 5 cycles after release.
  always @(negedge clk) begin
    if (!tgt_cfg_n) begin
      model_stat = 0; sdly = 0;
    end else if (auto_stat && !model_stat) begin
      sdly++;
      if (sdly >= 5) model_stat = 1;
    end
  end

  // Target-side receiver and monitors, sampled 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    clk_seen++;
    if (tgt_clk !== 1'b1) clk_bad++;
    if (src_rst) ridx = 0;
    else if (rst_n && tgt_valid) begin
      if (ridx >= 256 || tgt_data !== words[ridx]) mism++;
      ridx++;
    end
    if (rst_n && !tgt_cfg_n && tgt_valid) bad_pulse++;
    if (rst_n && cfg_err && tgt_valid) err_viol++;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, cnt, snap;
    void'($urandom(32'h5EED_C0F1));
    for (int i = 0; i < 256; i++) words[i] = DW'($urandom);

    negs(5);
    // R1 reset state
    chk(tgt_cfg_n === 1'b1, "R1 cfg_n in reset", tgt_cfg_n, 1);
    chk(tgt_valid === 1'b0 && src_ready === 1'b0, "R1 valid/ready in reset", tgt_valid, 0);
    rst_n = 1'b1;
    negs(3);
    chk(tgt_cfg_n === 1'b1 && cfg_done === 1'b0 && cfg_err === 1'b0, "R1 after reset",
        {tgt_cfg_n, cfg_done, cfg_err}, 3'b100);
    chk(tgt_valid === 1'b0 && src_ready === 1'b0, "R1 idle quiet", src_ready, 0);

    // ---- Run A: pulse, ready latency, overrun, random streaming, done ----
    src_len = 200; avail = 100; src_en = 1;
    pulse_start();
    n = 0;
    while (tgt_cfg_n && n < 5) begin @(negedge clk); n++; end
    cnt = 0;
    while (!tgt_cfg_n && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == PULSE, "R2 pulse length", cnt, PULSE);
    negs(20);
    chk(tgt_valid === 1'b0 && src_ready === 1'b0, "R3 no word before ready", tgt_valid, 0);

    @(negedge clk); tgt_ready = 1'b1;
    n = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (tgt_valid) begin n = i; break; end
    end
    chk(n == BOUND, "R3 ready-to-valid delay", n, BOUND);

    negs(12);
    drop_count(cnt);
    chk(cnt == BOUND, "R4 overrun words", cnt, BOUND);
    chk(cnt <= LAT, "R4 overrun within budget", cnt, LAT);

    avail = 70;
    for (int k = 0; k < 5; k++) begin
      tgt_ready = 1'b1;
      negs(10 + int'($urandom % 10));
      drop_count(cnt);
      chk(cnt <= BOUND, "R4 overrun under random source", cnt, BOUND);
    end

    for (int k = 0; k < 400 && ridx < src_len; k++) begin
      tgt_ready = 1'b1;
      negs(1 + int'($urandom % 12));
      tgt_ready = 1'b0;
      negs(1 + int'($urandom % 8));
    end
    tgt_ready = 1'b1;
    for (int k = 0; k < 2000 && ridx < src_len; k++) @(negedge clk);
    chk(ridx == src_len, "R6 word count", ridx, src_len);
    chk(mism == 0, "R6 word order/content", mism, 0);
    negs(5);
    chk(cfg_done === 1'b0, "R7 no done before target done", cfg_done, 0);
    tgt_done = 1'b1;
    negs(4);
    chk(cfg_done === 1'b1 && cfg_err === 1'b0, "R7 completion", {cfg_done, cfg_err}, 2'b10);

    // ---- Run B: restart from done, status never rises ----
    reset_src();
    src_len = 50; avail = 100; src_en = 1;
    auto_stat = 0; tgt_done = 1'b0; tgt_ready = 1'b1;
    pulse_start();
    n = 0;
    while (tgt_cfg_n && n < 5) begin @(negedge clk); n++; end
    chk(!tgt_cfg_n && !cfg_done, "R12 restart from done", tgt_cfg_n, 0);
    while (!tgt_cfg_n && n < 100) begin @(negedge clk); n++; end
    cnt = 0;
    for (int i = 0; i < STMO - 1; i++) begin
      @(negedge clk);
      cnt += int'(src_ready | tgt_valid);
    end
    chk(cfg_err === 1'b0, "R9 no error before timeout", cfg_err, 0);
    @(negedge clk);
    chk(cfg_err === 1'b1, "R9 status timeout", cfg_err, 1);
    chk(cnt == 0, "R11 ready ignored while status low", cnt, 0);

    // ---- Run C: restart from error, status loss mid-stream ----
    reset_src();
    src_len = 200; avail = 100; src_en = 1; auto_stat = 1;
    pulse_start();
    for (int k = 0; k < 600 && ridx < 30; k++) @(negedge clk);
    chk(ridx >= 30 && cfg_err === 1'b0, "R12 restart from error streams", ridx, 30);
    force_low = 1;
    negs(2);
    chk(cfg_err === 1'b0, "R5 error not early", cfg_err, 0);
    @(negedge clk);
    chk(cfg_err === 1'b1, "R5 error on third edge", cfg_err, 1);
    chk(src_ready === 1'b0 && tgt_valid === 1'b0, "R5 quiet on error", tgt_valid, 0);
    snap = ridx;
    negs(10);
    chk(ridx == snap, "R5 no words after error", ridx, snap);
    chk(err_viol == 0, "R5 no valid while in error", err_viol, 0);
    chk(mism == 0, "R6 order before status loss", mism, 0);
    force_low = 0;

    // ---- Run D: done never arrives ----
    reset_src();
    src_len = 20; avail = 60; src_en = 1;
    pulse_start();
    for (int k = 0; k < 1000 && ridx < src_len; k++) @(negedge clk);
    chk(ridx == src_len && cfg_err === 1'b0, "R8 stream finished cleanly", ridx, src_len);
    negs(DTMO + 10);
    chk(cfg_err === 1'b1 && cfg_done === 1'b0, "R8 done timeout", {cfg_err, cfg_done}, 2'b10);

    // R10 forwarded clock, R2 pulse quiet
    @(negedge clk);
    chk(tgt_clk === 1'b0, "R10 clock low phase", tgt_clk, 0);
    chk(clk_bad == 0 && clk_seen > 100, "R10 clock high phase", clk_bad, 0);
    chk(bad_pulse == 0, "R2 no word during pulse", bad_pulse, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule